// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer for a simple memory-mapped register bus. An up-counter advances on a slow time-base tick, optionally divided by a power-of-two prescaler. When the counter steps past its all-ones value it reloads from the load register and pulses a reset output for a fixed number of clock cycles. Software arms the timer with one ordered pair of 16-bit key words and disarms it with a different ordered pair. It services the timer by writing the trigger register with a value that differs from the one the register already holds, which copies the load value into the counter.

Writes to the four writable registers are posted. Each write is held in a per-register slot and takes effect on the second slow tick after the write (the `POST_TICKS` parameter). While that happens the slot shows a pending bit in the status register. The prescaler control and load registers are frozen while the timer runs, so a timeout cannot be stretched by accident. The timeout in ticks is the distance from the load value to the overflow point, 2^`CNT_W` minus the load value, multiplied by the prescaler division.

Top module: `kwdt_top`

## Requirements
- R1: After reset the timer is stopped, the control, load, status and counter reads are zero, the trigger register reads `TRIG_RST` (0x00005AA5) and `wdog_rst_o` is low.
- R2: Register word addresses are: control 0, load 1, trigger 2, key 3, status 4 (read only), counter 5 (read only). A bus write to a writable register sets that register's status bit (bit 0 control, bit 1 load, bit 2 trigger, bit 3 key) from the next cycle on. The value takes effect, and the bit clears, at the `POST_TICKS`-th slow tick after the write. A write to a register whose bit is still set is dropped.
- R3: The timer starts only when key value 0xBBBB takes effect and is followed directly by key value 0x4444 (bits 15:0 of the key register).
- R4: The timer stops only when key value 0xAAAA takes effect and is followed directly by key value 0x5555.
- R5: Any other key value returns the key sequence to idle and leaves the running state unchanged.
- R6: Control and load writes that take effect while the timer runs are discarded. While the timer is stopped they are applied.
- R7: While running, the counter adds one per step. With the control enable bit (bit 0) clear, a step is every slow tick. With it set, a step is every 2^p slow ticks, where p is control bits 3:1.
- R8: A trigger write that takes effect with a value different from the trigger register's contents loads the counter from the load register. A write of the same value does not.
- R9: A step taken at counter value all-ones loads the counter from the load register and drives `wdog_rst_o` high for `RST_CYC` (4) clock cycles, starting the cycle after that step.
- R10: While the timer is stopped the counter holds its value unless a trigger reload occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Slow time-base tick, one clock wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write word address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read word address |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| wdog_rst_o | output | 1 | Watchdog reset pulse |

## Verification
A pending bit is visible one clock after the write edge. A posted value, a key-sequence change and a trigger reload all appear in the clock that follows the second slow tick after the write. A counter step appears one clock after its tick, and the reset pulse rises one clock after the overflowing tick and lasts four clocks. The bench drives each write and each tick as a one-cycle pulse placed just after a rising edge. It queues each expected read value only after the stimulus that should produce it has passed through its edge, and the monitor compares the value at the following falling edge. This lets the pulse width be checked clock by clock.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  localparam int NSLOT   = 4;
  localparam int IX_CTRL = 0;
  localparam int IX_LOAD = 1;
  localparam int IX_TRIG = 2;
  localparam int IX_KEY  = 3;
  localparam logic [2:0] AD_STAT = 3'd4;
  localparam logic [2:0] AD_CNT  = 3'd5;

  localparam logic [15:0] KEY_ON1  = 16'hBBBB;
  localparam logic [15:0] KEY_ON2  = 16'h4444;
  localparam logic [15:0] KEY_OFF1 = 16'hAAAA;
  localparam logic [15:0] KEY_OFF2 = 16'h5555;

  typedef enum logic [1:0] {KS_IDLE, KS_ON_ARMED, KS_OFF_ARMED} key_st_e;

  typedef struct packed {
    key_st_e st;
    logic    run;
  } key_res_t;

  function automatic key_res_t key_step(key_st_e s, logic [15:0] k, logic run);
    key_res_t r;
    r.st  = KS_IDLE;
    r.run = run;
    if (k == KEY_ON1)                          r.st  = KS_ON_ARMED;
    else if (k == KEY_OFF1)                    r.st  = KS_OFF_ARMED;
    else if (s == KS_ON_ARMED  && k == KEY_ON2)  r.run = 1'b1;
    else if (s == KS_OFF_ARMED && k == KEY_OFF2) r.run = 1'b0;
    return r;
  endfunction

  // terminal value of the divider for a prescale exponent p
  function automatic int unsigned div_limit(int unsigned p);
    return (32'd1 << p) - 32'd1;
  endfunction

endpackage

// File: rtl/kwdt_post.sv
module kwdt_post #(
  parameter int DW         = 32,
  parameter int POST_TICKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          wr_hit_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          pend_o,
  output logic          commit_o,
  output logic [DW-1:0] data_o
);
  localparam int CW = $clog2(POST_TICKS + 1);

  logic [CW-1:0] left_q;

  assign commit_o = pend_o && tick_i && (left_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
      left_q <= '0;
      data_o <= '0;
    end else if (wr_hit_i && !pend_o) begin
      pend_o <= 1'b1;
      left_q <= CW'(POST_TICKS);
      data_o <= wr_data_i;
    end else if (pend_o && tick_i) begin
      left_q <= left_q - CW'(1);
      if (left_q == CW'(1)) pend_o <= 1'b0;
    end
  end

  AST_POST_SET:   assert property (@(posedge clk) disable iff (!rst_n) (wr_hit_i && !pend_o) |=> pend_o); // R2
  AST_POST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) commit_o |=> !pend_o); // R2
  AST_POST_DROP:  assert property (@(posedge clk) disable iff (!rst_n) (pend_o && wr_hit_i) |=> $stable(data_o)); // R2

endmodule

// File: rtl/kwdt_keyfsm.sv
module kwdt_keyfsm
  import kwdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_commit_i,
  input  logic [15:0] key_word_i,
  output logic        running_o,
  output key_st_e     state_o
);
  key_res_t nxt;

  always_comb nxt = key_step(state_o, key_word_i, running_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_o   <= KS_IDLE;
      running_o <= 1'b0;
    end else if (key_commit_i) begin
      state_o   <= nxt.st;
      running_o <= nxt.run;
    end
  end

  logic bad_key;
  assign bad_key = key_commit_i && key_word_i != KEY_ON1 && key_word_i != KEY_OFF1 &&
                   !(state_o == KS_ON_ARMED  && key_word_i == KEY_ON2) &&
                   !(state_o == KS_OFF_ARMED && key_word_i == KEY_OFF2);

  AST_START_ORDER: assert property (@(posedge clk) disable iff (!rst_n) $rose(running_o) |-> $past(state_o) == KS_ON_ARMED); // R3
  AST_STOP_ORDER:  assert property (@(posedge clk) disable iff (!rst_n) $fell(running_o) |-> $past(state_o) == KS_OFF_ARMED); // R4
  AST_BAD_KEY:     assert property (@(posedge clk) disable iff (!rst_n) bad_key |=> ($stable(running_o) && state_o == KS_IDLE)); // R5

endmodule

// File: rtl/kwdt_count.sv
module kwdt_count
  import kwdt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PSC_W   = 3,
  parameter int RST_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             running_i,
  input  logic             psc_en_i,
  input  logic [PSC_W-1:0] psc_val_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wdog_rst_o
);
  localparam int DIV_W = (1 << PSC_W) - 1;
  localparam int RC_W  = $clog2(RST_CYC + 1);

  logic [DIV_W-1:0] div_q;
  logic [RC_W-1:0]  rst_left_q;
  logic             div_hit;
  logic             step;
  logic             ovf;

  assign div_hit = !psc_en_i || (div_q == DIV_W'(div_limit(32'(psc_val_i))));
  assign step    = running_i && tick_i && div_hit;
  assign ovf     = step && !reload_i && (&cnt_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   div_q <= '0;
    else if (!running_i || reload_i) div_q <= '0;
    else if (tick_i)              div_q <= div_hit ? '0 : div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_o <= '0;
    else if (reload_i || ovf)  cnt_o <= load_i;
    else if (step)             cnt_o <= cnt_o + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rst_left_q <= '0;
    else if (ovf)                rst_left_q <= RC_W'(RST_CYC);
    else if (rst_left_q != '0)   rst_left_q <= rst_left_q - RC_W'(1);
  end

  assign wdog_rst_o = (rst_left_q != '0);

  AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n) ovf |=> cnt_o == $past(load_i)); // R9
  AST_RST_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) ovf |=> wdog_rst_o); // R9
  AST_TRIG_LOAD:  assert property (@(posedge clk) disable iff (!rst_n) reload_i |=> cnt_o == $past(load_i)); // R8
  AST_STEP_ONE:   assert property (@(posedge clk) disable iff (!rst_n) (step && !reload_i && !(&cnt_o)) |=> cnt_o == $past(cnt_o) + CNT_W'(1)); // R7
  AST_HOLD_STOP:  assert property (@(posedge clk) disable iff (!rst_n) (!running_i && !reload_i) |=> $stable(cnt_o)); // R10

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int          CNT_W      = 16,
  parameter int          PSC_W      = 3,
  parameter int          POST_TICKS = 2,
  parameter int          RST_CYC    = 4,
  parameter logic [31:0] TRIG_RST   = 32'h0000_5AA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        wr_en_i,
  input  logic [2:0]  wr_addr_i,
  input  logic [31:0] wr_data_i,
  input  logic [2:0]  rd_addr_i,
  output logic [31:0] rd_data_o,
  output logic        wdog_rst_o
);
  localparam int CTRL_W = PSC_W + 1;

  logic [NSLOT-1:0] pend;
  logic [NSLOT-1:0] commit;
  logic [31:0]      pdata [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    kwdt_post #(.DW(32), .POST_TICKS(POST_TICKS)) i_post (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .wr_hit_i (wr_en_i && (wr_addr_i == 3'(g))),
      .wr_data_i(wr_data_i),
      .pend_o   (pend[g]),
      .commit_o (commit[g]),
      .data_o   (pdata[g])
    );
  end

  logic              running;
  key_st_e           key_state;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  load_q;
  logic [31:0]       trig_q;
  logic              reload;
  logic [CNT_W-1:0]  cnt;

  kwdt_keyfsm i_keys (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_commit_i(commit[IX_KEY]),
    .key_word_i  (pdata[IX_KEY][15:0]),
    .running_o   (running),
    .state_o     (key_state)
  );

  assign reload = commit[IX_TRIG] && (pdata[IX_TRIG] != trig_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      trig_q <= TRIG_RST;
    end else begin
      if (commit[IX_CTRL] && !running) ctrl_q <= pdata[IX_CTRL][CTRL_W-1:0];
      if (commit[IX_LOAD] && !running) load_q <= pdata[IX_LOAD][CNT_W-1:0];
      if (commit[IX_TRIG])             trig_q <= pdata[IX_TRIG];
    end
  end

  kwdt_count #(.CNT_W(CNT_W), .PSC_W(PSC_W), .RST_CYC(RST_CYC)) i_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .running_i (running),
    .psc_en_i  (ctrl_q[0]),
    .psc_val_i (ctrl_q[CTRL_W-1:1]),
    .reload_i  (reload),
    .load_i    (load_q),
    .cnt_o     (cnt),
    .wdog_rst_o(wdog_rst_o)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      3'(IX_CTRL): rd_data_o = 32'(ctrl_q);
      3'(IX_LOAD): rd_data_o = 32'(load_q);
      3'(IX_TRIG): rd_data_o = trig_q;
      AD_STAT:     rd_data_o = 32'(pend);
      AD_CNT:      rd_data_o = 32'(cnt);
      default:     rd_data_o = '0;
    endcase
  end

  AST_CTRL_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (running && commit[IX_CTRL]) |=> $stable(ctrl_q)); // R6
  AST_LOAD_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (running && commit[IX_LOAD]) |=> $stable(load_q)); // R6
  AST_TRIG_SAME: assert property (@(posedge clk) disable iff (!rst_n) (commit[IX_TRIG] && pdata[IX_TRIG] == trig_q) |=> $stable(trig_q)); // R8

endmodule

// File: tb/test_kwdt_top.sv
module test_kwdt_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        wdog_rst_o;

  kwdt_top i_kwdt_top (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .wdog_rst_o(wdog_rst_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [31:0] exp;
    bit          is_rst;
    logic [2:0]  addr;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  logic mon_req = 1'b0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // monitor: compares at the falling edge of the cycle the check was queued in
  always @(negedge clk) begin
    if (mon_req && exp_q.size() > 0) begin
      exp_t it;
      logic [31:0] act;
      it = exp_q.pop_front();
      act = it.is_rst ? 32'(wdog_rst_o) : rd_data_o;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, act, it.exp);
      end
    end
  end

  task automatic expect_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    @(posedge clk); #1;
    rd_addr_i = a;
    it.exp = e; it.is_rst = 1'b0; it.addr = a; it.tag = tag;
    exp_q.push_back(it);
    mon_req = 1'b1;
    @(negedge clk); #1;
    mon_req = 1'b0;
  endtask

  task automatic expect_rst(input logic e, input string tag);
    exp_t it;
    @(posedge clk); #1;
    it.exp = 32'(e); it.is_rst = 1'b1; it.addr = '0; it.tag = tag;
    exp_q.push_back(it);
    mon_req = 1'b1;
    @(negedge clk); #1;
    mon_req = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; tick_i = 1'b1;
      @(posedge clk); #1; tick_i = 1'b0;
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1; wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk); #1; wr_en_i = 1'b0;
  endtask

  task automatic post(input logic [2:0] a, input logic [31:0] d);
    bus_wr(a, d);
    tick(2);
  endtask

  localparam logic [2:0] A_CTRL = 3'd0, A_LOAD = 3'd1, A_TRIG = 3'd2,
                         A_KEY = 3'd3, A_STAT = 3'd4, A_CNT = 3'd5;

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    expect_rd(A_CTRL, 32'h0, "R1");
    expect_rd(A_LOAD, 32'h0, "R1");
    expect_rd(A_TRIG, 32'h5AA5, "R1");
    expect_rd(A_STAT, 32'h0, "R1");
    expect_rd(A_CNT, 32'h0, "R1");
    expect_rst(1'b0, "R1");
    // R2 posted write, pending flag timing
    bus_wr(A_LOAD, 32'hFFF0);
    expect_rd(A_STAT, 32'h2, "R2");
    tick(1);
    expect_rd(A_STAT, 32'h2, "R2");
    expect_rd(A_LOAD, 32'h0, "R2");
    tick(1);
    expect_rd(A_STAT, 32'h0, "R2");
    expect_rd(A_LOAD, 32'hFFF0, "R2");
    // R2 second write while pending is dropped
    bus_wr(A_LOAD, 32'h1111);
    bus_wr(A_LOAD, 32'h2222);
    tick(2);
    expect_rd(A_LOAD, 32'h1111, "R2");
    post(A_LOAD, 32'hFFF0);
    bus_wr(A_KEY, 32'hBBBB);
    expect_rd(A_STAT, 32'h8, "R2");
    tick(2);
    // R5 broken start sequence
    post(A_KEY, 32'h1111);
    post(A_KEY, 32'h4444);
    tick(3);
    expect_rd(A_CNT, 32'h0, "R5");
    // R3 proper start, R8 reload
    post(A_KEY, 32'hBBBB);
    post(A_KEY, 32'h4444);
    post(A_TRIG, 32'h3C3C);
    expect_rd(A_CNT, 32'hFFF0, "R8");
    tick(3);
    expect_rd(A_CNT, 32'hFFF3, "R3");
    post(A_TRIG, 32'h3C3C);
    expect_rd(A_CNT, 32'hFFF5, "R8");
    // R6 locked while running
    post(A_LOAD, 32'h0);
    expect_rd(A_LOAD, 32'hFFF0, "R6");
    post(A_CTRL, 32'h3);
    expect_rd(A_CTRL, 32'h0, "R6");
    expect_rd(A_CNT, 32'hFFF9, "R7");
    // R9 overflow
    tick(6);
    expect_rd(A_CNT, 32'hFFFF, "R9");
    expect_rst(1'b0, "R9");
    tick(1);
    expect_rst(1'b1, "R9");
    expect_rst(1'b1, "R9");
    expect_rst(1'b1, "R9");
    expect_rst(1'b0, "R9");
    expect_rd(A_CNT, 32'hFFF0, "R9");
    // R4 stop, R10 hold
    post(A_KEY, 32'hAAAA);
    post(A_KEY, 32'h5555);
    expect_rd(A_CNT, 32'hFFF4, "R4");
    tick(3);
    expect_rd(A_CNT, 32'hFFF4, "R10");
    // R6 applied while stopped, R7 prescaler divide by 2
    post(A_CTRL, 32'h3);
    expect_rd(A_CTRL, 32'h3, "R6");
    post(A_KEY, 32'hBBBB);
    post(A_KEY, 32'h4444);
    post(A_TRIG, 32'hC3C3);
    expect_rd(A_CNT, 32'hFFF0, "R8");
    expect_rd(A_TRIG, 32'hC3C3, "R8");
    tick(4);
    expect_rd(A_CNT, 32'hFFF2, "R7");
    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard actual=%0d expected=0 items left", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule